// File: doc/BRIEF.md
# Overcurrent Circuit Breaker Controller

This block is the digital side of a hot-swap circuit breaker. Four analog comparators watch the sense voltage. Each one reports when the voltage is above 1x, 2x, 3x or 4x the normal trip level, where the normal level corresponds to 50 mV. While the board is being inserted, and before the first power-good request arrives, the block watches a raised level chosen by a 2-bit code. Once power-good is requested, it drops back to the normal level.

An overcurrent has to stay present for a programmable minimum time before it counts as a trip. When a trip is qualified, the block turns off the gate drive, forces every power-good output inactive and latches a fault flag. It then waits a fixed retry time and turns the gate back on. The retry mode sets how often this may happen: never, once, four times or without limit. A trip that arrives with no retries left locks the gate off and raises a retry-failure flag. A single-cycle clear write drops both flags, restarts the retry count and releases a locked breaker.

Top module: `oc_breaker`

## Requirements
- R1: After reset the gate is on, `oc_fault_o` and `retry_fail_o` are 0, and `pg_o` equals `pg_req_i`.
- R2: Bit k of `oc_cmp_i` means the sense voltage exceeds (k+1) times the normal level. While `pg_req_i[0]` is 0, the monitored bit is `oc_cmp_i[ins_code_i]`. While `pg_req_i[0]` is 1, the monitored bit is `oc_cmp_i[0]`.
- R3: With `filt_code_i` = 00, a monitored bit that is high for one cycle trips the breaker. Codes 01, 10 and 11 require the bit to stay high without a gap for 1, 2 or 4 times FILT_UNIT_US microseconds (clock cycles derived from CLK_HZ). A shorter pulse is ignored, and any low cycle restarts the count.
- R4: On the clock edge that qualifies a trip, the gate turns off, every bit of `pg_o` goes to 0 and `oc_fault_o` becomes 1.
- R5: After a trip that still has a retry available, the gate stays off for exactly RETRY_US microseconds' worth of cycles and then turns on again, with the filter count restarted.
- R6: `retry_mode_i` sets the allowed retries: 00 none, 01 one, 10 four, 11 unlimited.
- R7: A trip that arrives with no retry left sets `retry_fail_o` and holds the gate off until a clear. Mode 11 never sets `retry_fail_o`.
- R8: `oc_fault_o` and `retry_fail_o` stay set until `clr_i` is pulsed. The clear drops both flags, restarts the retry count and turns a locked-off gate back on.
- R9: `oc_fault_o` stays set after a successful retry has turned the gate back on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_cmp_i | input | 4 | Comparator outputs, bit k = above (k+1) times the normal level |
| pg_req_i | input | NUM_PG | Power-good requests from upstream; bit 0 also ends insertion |
| filt_code_i | input | 2 | Minimum overcurrent width code |
| ins_code_i | input | 2 | Insertion trip-level code (1x to 4x) |
| retry_mode_i | input | 2 | Retry allowance code |
| clr_i | input | 1 | Fault-clear write strobe |
| gate_on_o | output | 1 | Gate drive enable |
| pg_o | output | NUM_PG | Power-good outputs, forced to 0 while the gate is off |
| oc_fault_o | output | 1 | Sticky overcurrent fault flag |
| retry_fail_o | output | 1 | Sticky failure-after-retry flag |

## Verification
The bench builds the block with CLK_HZ = 2 MHz, FILT_UNIT_US = 5, RETRY_US = 20 and NUM_PG = 4. With these values the filter widths are 10, 20 and 40 cycles and the retry wait is 40 cycles. That makes pulses one cycle shorter than each width, and pulses of exactly the width, cheap to drive. It also lets the bench walk a full four-retry sequence and a long run of unlimited retries within a few hundred cycles. It can then check the exact cycle on which the gate comes back on.

// File: rtl/oc_breaker.sv
module oc_breaker #(
  parameter int CLK_HZ       = 100_000_000,
  parameter int FILT_UNIT_US = 5,
  parameter int RETRY_US     = 100,
  parameter int NUM_PG       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        oc_cmp_i,
  input  logic [NUM_PG-1:0] pg_req_i,
  input  logic [1:0]        filt_code_i,
  input  logic [1:0]        ins_code_i,
  input  logic [1:0]        retry_mode_i,
  input  logic              clr_i,
  output logic              gate_on_o,
  output logic [NUM_PG-1:0] pg_o,
  output logic              oc_fault_o,
  output logic              retry_fail_o
);

  localparam int TPU       = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1;
  localparam int W1        = (FILT_UNIT_US * TPU < 1) ? 1 : FILT_UNIT_US * TPU;
  localparam int W2        = 2 * W1;
  localparam int W3        = 4 * W1;
  localparam int RUN_W     = $clog2(W3 + 1);
  localparam int RETRY_CYC = (RETRY_US * TPU < 1) ? 1 : RETRY_US * TPU;
  localparam int TMR_W     = $clog2(RETRY_CYC + 1);

  typedef enum logic [1:0] {S_ON, S_WAIT, S_LOCK} st_t;

  st_t              state;
  logic [RUN_W-1:0] run_cnt, need_m1;
  logic [TMR_W-1:0] tmr;
  logic [2:0]       used, lim;
  logic [1:0]       lvl_sel;
  logic             oc_raw, qual, retry_ok;

  assign lvl_sel = pg_req_i[0] ? 2'd0 : ins_code_i;
  assign oc_raw  = oc_cmp_i[lvl_sel];

  always_comb begin
    case (filt_code_i)
      2'b00:   need_m1 = '0;
      2'b01:   need_m1 = RUN_W'(W1 - 1);
      2'b10:   need_m1 = RUN_W'(W2 - 1);
      default: need_m1 = RUN_W'(W3 - 1);
    endcase
  end

  assign qual = (state == S_ON) && oc_raw && (run_cnt >= need_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (state != S_ON || !oc_raw)
      run_cnt <= '0;
    else if (run_cnt != RUN_W'(W3))
      run_cnt <= run_cnt + 1'b1;
  end

  always_comb begin
    case (retry_mode_i)
      2'b01:   lim = 3'd1;
      2'b10:   lim = 3'd4;
      default: lim = 3'd0;
    endcase
  end

  assign retry_ok = (retry_mode_i == 2'b11) || (used < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_ON;
      tmr          <= '0;
      used         <= '0;
      oc_fault_o   <= 1'b0;
      retry_fail_o <= 1'b0;
    end else begin
      if (clr_i) begin
        used         <= '0;
        oc_fault_o   <= 1'b0;
        retry_fail_o <= 1'b0;
        if (state == S_LOCK) state <= S_ON;
      end
      if (qual) begin
        oc_fault_o <= 1'b1;
        if (retry_ok) begin
          state <= S_WAIT;
          tmr   <= '0;
          if (retry_mode_i != 2'b11) used <= used + 3'd1;
        end else begin
          state        <= S_LOCK;
          retry_fail_o <= 1'b1;
        end
      end else if (state == S_WAIT) begin
        if (tmr == TMR_W'(RETRY_CYC - 1)) state <= S_ON;
        else tmr <= tmr + 1'b1;
      end
    end
  end

  assign gate_on_o = (state == S_ON);
  assign pg_o      = gate_on_o ? pg_req_i : '0;

  a_r4_trip_cuts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> (!gate_on_o && oc_fault_o && pg_o == '0));

  a_r7_no_retry_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && retry_mode_i == 2'b00) |=> (retry_fail_o && state == S_LOCK));

  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK && !clr_i) |=> !gate_on_o);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault_o && !clr_i) |=> oc_fault_o);

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_fail_o && !clr_i) |=> retry_fail_o);

  a_r5_wait_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && tmr != TMR_W'(RETRY_CYC - 1)) |=> !gate_on_o);

endmodule

// File: tb/oc_breaker_tb.sv
module oc_breaker_tb;
  localparam int NPG = 4;
  localparam int RW  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] oc_cmp = '0;
  logic [NPG-1:0] pg_req = 4'b1111;
  logic [1:0] filt = '0, ins = '0, rmode = '0;
  logic clr = 1'b0;
  logic gate_on, oc_fault, retry_fail;
  logic [NPG-1:0] pg;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  oc_breaker #(.CLK_HZ(2_000_000), .FILT_UNIT_US(5), .RETRY_US(20), .NUM_PG(NPG)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_cmp_i(oc_cmp), .pg_req_i(pg_req),
    .filt_code_i(filt), .ins_code_i(ins), .retry_mode_i(rmode), .clr_i(clr),
    .gate_on_o(gate_on), .pg_o(pg), .oc_fault_o(oc_fault), .retry_fail_o(retry_fail));

  typedef struct packed {
    logic [1:0] f; logic [1:0] ins; logic pg0; logic [3:0] cmp; logic [7:0] len; logic trip;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{2'd0, 2'd0, 1'b1, 4'b0001, 8'd1,  1'b1},
    '{2'd1, 2'd0, 1'b1, 4'b0001, 8'd9,  1'b0},
    '{2'd1, 2'd0, 1'b1, 4'b0001, 8'd10, 1'b1},
    '{2'd2, 2'd0, 1'b1, 4'b0001, 8'd19, 1'b0},
    '{2'd2, 2'd0, 1'b1, 4'b0001, 8'd20, 1'b1},
    '{2'd3, 2'd0, 1'b1, 4'b0001, 8'd39, 1'b0},
    '{2'd3, 2'd0, 1'b1, 4'b0001, 8'd40, 1'b1},
    '{2'd0, 2'd3, 1'b0, 4'b0111, 8'd3,  1'b0},
    '{2'd0, 2'd3, 1'b0, 4'b1111, 8'd1,  1'b1},
    '{2'd0, 2'd1, 1'b0, 4'b0011, 8'd1,  1'b1},
    '{2'd0, 2'd2, 1'b0, 4'b0011, 8'd5,  1'b0},
    '{2'd0, 2'd3, 1'b1, 4'b0001, 8'd1,  1'b1},
    '{2'd0, 2'd0, 1'b0, 4'b0001, 8'd1,  1'b1}
  };

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    oc_cmp = '0;
    clr = 1'b1; cyc(1);
    clr = 1'b0; cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rises;
    logic prev;
    cyc(3); rst_n = 1'b1; cyc(2);
    check("R1 gate after reset", gate_on, 1);
    check("R1 fault after reset", oc_fault, 0);
    check("R1 fail after reset", retry_fail, 0);
    check("R1 pg after reset", pg, 4'b1111);

    rmode = 2'b00;
    foreach (VECS[i]) begin
      filt = VECS[i].f; ins = VECS[i].ins; pg_req = {3'b111, VECS[i].pg0};
      cyc(1);
      oc_cmp = VECS[i].cmp;
      cyc(VECS[i].len);
      oc_cmp = '0;
      cyc(2);
      check($sformatf("R2/R3 vec%0d fault", i), oc_fault, VECS[i].trip);
      check($sformatf("R4 vec%0d gate", i), gate_on, !VECS[i].trip);
      check($sformatf("R4 vec%0d pg", i), pg, VECS[i].trip ? 0 : {3'b111, VECS[i].pg0});
      check($sformatf("R7 vec%0d fail", i), retry_fail, VECS[i].trip);
      do_clear();
      check($sformatf("R8 vec%0d cleared gate", i), gate_on, 1);
    end
    pg_req = 4'b1111; ins = 2'd0;

    // R3: a gap restarts the width count
    filt = 2'b01; cyc(1);
    oc_cmp = 4'b0001; cyc(6); oc_cmp = '0; cyc(1); oc_cmp = 4'b0001; cyc(6); oc_cmp = '0; cyc(2);
    check("R3 gap restarts filter", oc_fault, 0);

    // R5/R6/R7: one retry, persistent overcurrent
    filt = 2'b00; rmode = 2'b01; cyc(1);
    oc_cmp = 4'b0001; cyc(1);
    check("R4 first trip gate", gate_on, 0);
    check("R7 fail after first trip mode01", retry_fail, 0);
    cyc(RW - 1);
    check("R5 still off at end of wait", gate_on, 0);
    cyc(1);
    check("R5 gate back after wait", gate_on, 1);
    cyc(1);
    check("R7 second trip locks", retry_fail, 1);
    check("R7 second trip gate", gate_on, 0);
    cyc(100);
    check("R7 lock holds", gate_on, 0);
    do_clear();
    check("R8 clear fault", oc_fault, 0);
    check("R8 clear fail", retry_fail, 0);
    check("R8 clear releases gate", gate_on, 1);

    // R6: four retries
    rmode = 2'b10; cyc(1);
    oc_cmp = 4'b0001; rises = 0; prev = gate_on;
    for (int k = 0; k < 260; k++) begin
      cyc(1);
      if (gate_on && !prev) rises++;
      prev = gate_on;
    end
    check("R6 four retries", rises, 4);
    check("R7 fail after four", retry_fail, 1);
    do_clear();

    // R6/R7/R9: unlimited retries
    rmode = 2'b11; cyc(1);
    oc_cmp = 4'b0001; rises = 0; prev = gate_on;
    for (int k = 0; k < 300; k++) begin
      cyc(1);
      if (gate_on && !prev) rises++;
      prev = gate_on;
    end
    check("R6 unlimited retries", rises, 7);
    check("R7 no fail in mode11", retry_fail, 0);
    oc_cmp = '0; cyc(RW + 5);
    check("R9 gate on after good retry", gate_on, 1);
    check("R9 fault stays set", oc_fault, 1);
    do_clear();
    check("R8 clear after retry", oc_fault, 0);

    // R8: clear restarts the retry count
    rmode = 2'b01; cyc(1);
    oc_cmp = 4'b0001; cyc(1); oc_cmp = '0; cyc(RW + 3);
    check("R9 gate on after single retry", gate_on, 1);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
    oc_cmp = 4'b0001; cyc(1);
    check("R8 restarted count allows retry", retry_fail, 0);
    cyc(RW);
    check("R8 retry happens after clear", gate_on, 1);
    cyc(1);
    check("R8 then locks", retry_fail, 1);
    do_clear();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule